// File: doc/BRIEF.md
# Standby-Retained Scratchpad RAM

This block is a 128-byte data RAM that sits at the very bottom of a 16-bit address space and is reached over an 8-bit shared data bus. An access is taken when the address falls in the RAM window, the address-valid qualifier is high and the RAM-enable pin, after a two-flop synchroniser, is high. The block raises a select flag so that external logic can turn off any memory that overlaps the window. It also raises a drive-enable so that the shared bus points outward while the internal RAM is in use.

Each bus cycle has a high phase and a low phase of the bus strobe. Address, direction and write data are captured on every clock edge during the high phase. A read returns the addressed byte while the strobe is still high. A write is committed on the clock edge at which the strobe is first seen low.

The array has two parts. The bottom 32 bytes keep their contents while main power is absent. The upper 96 bytes lose their contents, and the model marks this by filling them with a fixed poison byte on every clock edge at which power is flagged as bad.

Top module: `scratch_ram`

## Requirements
- R1: The select flag `int_sel` can be high only for addresses 0x0000 to 0x007F. An access to any address with a bit above bit 6 set is ignored: writing 0x0085 leaves byte 0x05 unchanged, and reading it returns 0x00.
- R2: After `ram_en` has been low for two clock edges, `int_sel` is low, reads return 0x00 and writes do not change the array.
- R3: Bytes 0x00 to 0x1F keep their contents across a period with `pwr_good` low.
- R4: `dbus_drive` is high exactly when `int_sel` and `bus_e` are both high.
- R5: With `addr_valid` low there is no select and no effect on the array.
- R6: `rd_wr_n` high means read and low means write. During a write cycle `rdata` stays 0x00.
- R7: A write stores the data and address that were captured during the strobe-high phase. It commits on the clock edge where `bus_e` was high on the previous edge and is low on this one.
- R8: On each clock edge with `pwr_good` low, bytes 0x20 to 0x7F become the poison byte 0xA5, and no write takes effect in either region.
- R9: While `bus_e` is high and the captured access was a selected read, `rdata` shows the byte at the captured address. In every other case `rdata` is 0x00.
- R10: While `rst_n` is low, `int_sel`, `dbus_drive` and `rdata` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr_valid | input | 1 | Address qualifier |
| ram_en | input | 1 | Asynchronous RAM enable pin |
| bus_e | input | 1 | Bus strobe level, high phase = address phase |
| pwr_good | input | 1 | Main power present |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus |
| dbus_drive | output | 1 | Shared bus driven outward |
| int_sel | output | 1 | Internal RAM selected |

## Verification
The assertions take three things for granted. First, `bus_e` is a level that stays constant over at least one clock edge in each phase. Second, `ram_en` is allowed two clock edges to pass through the synchroniser before its effect is judged. Third, the address, the direction and the qualifier stay stable for the whole high phase. The stimulus honours all three. Every bus cycle is driven as exactly two clock periods, one with the strobe high and one with it low. After each change of `ram_en` the stimulus waits three clock periods. The random addresses are biased toward the window, with some that fall outside it.

// File: rtl/scratch_ram_pkg.sv
package scratch_ram_pkg;
  localparam int unsigned SR_ADDR_W  = 16;
  localparam int unsigned SR_DATA_W  = 8;
  localparam int unsigned SR_DEPTH   = 128;
  localparam int unsigned SR_KEEP    = 32;
  localparam logic [7:0]  SR_POISON  = 8'hA5;
endpackage

// File: rtl/scratch_ram_sync.sv
module scratch_ram_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_async;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scratch_ram_decode.sv
module scratch_ram_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_valid,
  input  logic              en_sync,
  output logic              hit
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic in_window;

  always_comb begin
    in_window = (addr[ADDR_W-1:IDX_W] == '0);
    hit       = in_window & addr_valid & en_sync;
  end
endmodule

// File: rtl/scratch_ram_bank.sv
module scratch_ram_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 32,
  parameter bit          VOLATILE = 1'b0,
  parameter logic [DATA_W-1:0] POISON = '0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              power_ok,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_go;

  assign wr_go = we & power_ok;
  assign rdata = mem[raddr];

  generate
    if (VOLATILE) begin : g_volatile
      always_ff @(posedge clk) begin
        if (!power_ok) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= POISON;
        end else if (wr_go) begin
          mem[waddr] <= wdata;
        end
      end
    end else begin : g_retained
      always_ff @(posedge clk) begin
        if (wr_go) mem[waddr] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram
  import scratch_ram_pkg::*;
#(
  parameter int unsigned ADDR_W     = SR_ADDR_W,
  parameter int unsigned DATA_W     = SR_DATA_W,
  parameter int unsigned DEPTH      = SR_DEPTH,
  parameter int unsigned KEEP_DEPTH = SR_KEEP,
  parameter logic [DATA_W-1:0] POISON = SR_POISON
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr_n,
  input  logic              addr_valid,
  input  logic              ram_en,
  input  logic              bus_e,
  input  logic              pwr_good,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dbus_drive,
  output logic              int_sel
);
  localparam int unsigned IDX_W    = $clog2(DEPTH);
  localparam int unsigned VOL_D    = DEPTH - KEEP_DEPTH;
  localparam int unsigned KAW      = $clog2(KEEP_DEPTH);
  localparam int unsigned VAW      = $clog2(VOL_D);

  logic              en_s;
  logic              hit;

  logic              e_q;
  logic              cap_sel_q, cap_sel_d;
  logic              cap_rd_q,  cap_rd_d;
  logic [IDX_W-1:0]  cap_addr_q, cap_addr_d;
  logic [DATA_W-1:0] cap_data_q, cap_data_d;

  logic              commit;
  logic              in_keep;
  logic [IDX_W-1:0]  vol_idx;
  logic              keep_we, vol_we;
  logic [DATA_W-1:0] keep_rd, vol_rd;

  scratch_ram_sync #(.STAGES(2)) u_en_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ram_en),
    .q_sync  (en_s)
  );

  scratch_ram_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_decode (
    .addr       (addr),
    .addr_valid (addr_valid),
    .en_sync    (en_s),
    .hit        (hit)
  );

  assign int_sel    = hit;
  assign dbus_drive = hit & bus_e;

  always_comb begin
    cap_sel_d  = cap_sel_q;
    cap_rd_d   = cap_rd_q;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    if (bus_e) begin
      cap_sel_d  = hit;
      cap_rd_d   = rd_wr_n;
      cap_addr_d = addr[IDX_W-1:0];
      cap_data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q        <= 1'b0;
      cap_sel_q  <= 1'b0;
      cap_rd_q   <= 1'b1;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      e_q        <= bus_e;
      cap_sel_q  <= cap_sel_d;
      cap_rd_q   <= cap_rd_d;
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
    end
  end

  always_comb begin
    commit  = e_q & ~bus_e & cap_sel_q & ~cap_rd_q;
    in_keep = (cap_addr_q < IDX_W'(KEEP_DEPTH));
    vol_idx = cap_addr_q - IDX_W'(KEEP_DEPTH);
    keep_we = commit & in_keep;
    vol_we  = commit & ~in_keep;
  end

  scratch_ram_bank #(
    .DATA_W(DATA_W), .DEPTH(KEEP_DEPTH), .VOLATILE(1'b0), .POISON(POISON)
  ) u_keep (
    .clk      (clk),
    .power_ok (pwr_good),
    .we       (keep_we),
    .waddr    (cap_addr_q[KAW-1:0]),
    .wdata    (cap_data_q),
    .raddr    (cap_addr_q[KAW-1:0]),
    .rdata    (keep_rd)
  );

  scratch_ram_bank #(
    .DATA_W(DATA_W), .DEPTH(VOL_D), .VOLATILE(1'b1), .POISON(POISON)
  ) u_vol (
    .clk      (clk),
    .power_ok (pwr_good),
    .we       (vol_we),
    .waddr    (vol_idx[VAW-1:0]),
    .wdata    (cap_data_q),
    .raddr    (vol_idx[VAW-1:0]),
    .rdata    (vol_rd)
  );

  always_comb begin
    rdata = '0;
    if (bus_e && cap_sel_q && cap_rd_q) rdata = in_keep ? keep_rd : vol_rd;
  end
endmodule

// File: rtl/scratch_ram_chk.sv
module scratch_ram_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_valid,
  input logic              ram_en,
  input logic              bus_e,
  input logic [DATA_W-1:0] rdata,
  input logic              dbus_drive,
  input logic              int_sel
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (addr[ADDR_W-1:IDX_W] == '0)); // R1

  AST_SEL_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ram_en, 1) && !$past(ram_en, 2)) |-> !int_sel); // R2

  AST_DRIVE_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_drive == (int_sel && bus_e)); // R4

  AST_NO_SEL_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> !int_sel); // R5

  AST_RDATA_QUIET_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_e |-> (rdata == '0)); // R9
endmodule

bind scratch_ram scratch_ram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .addr_valid (addr_valid),
  .ram_en     (ram_en),
  .bus_e      (bus_e),
  .rdata      (rdata),
  .dbus_drive (dbus_drive),
  .int_sel    (int_sel)
);

// File: tb/scratch_ram_test.sv
module scratch_ram_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd_wr_n;
  logic        addr_valid;
  logic        ram_en;
  logic        bus_e;
  logic        pwr_good;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        dbus_drive;
  logic        int_sel;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;
  logic [7:0]  model [128];
  bit          en_model;

  always #2.5 clk = ~clk;

  scratch_ram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr_n(rd_wr_n),
    .addr_valid(addr_valid), .ram_en(ram_en), .bus_e(bus_e),
    .pwr_good(pwr_good), .wdata(wdata), .rdata(rdata),
    .dbus_drive(dbus_drive), .int_sel(int_sel)
  );

  function automatic bit exp_sel(input logic [15:0] a, input bit v);
    return (a < 16'h0080) && v && en_model;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input bit rw, input bit v);
    return (exp_sel(a, v) && rw) ? model[a[6:0]] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One bus cycle: strobe high for one clock, low for one clock.
  task automatic bus_cycle(input logic [15:0] a, input bit rw, input logic [7:0] d,
                           input bit v, input string req);
    logic [7:0] e_rd;
    bit         e_sel;
    e_sel = exp_sel(a, v);
    e_rd  = exp_rd(a, rw, v);
    addr = a; rd_wr_n = rw; wdata = d; addr_valid = v; bus_e = 1'b1;
    @(negedge clk);
    check({req, " R1/R5 int_sel"}, {31'd0, int_sel}, {31'd0, e_sel});
    check("R4 dbus_drive", {31'd0, dbus_drive}, {31'd0, e_sel});
    check({req, " R9/R6 rdata"}, {24'd0, rdata}, {24'd0, e_rd});
    bus_e = 1'b0;
    @(negedge clk);
    if (e_sel && !rw && pwr_good) model[a[6:0]] = d;
  endtask

  task automatic set_en(input bit e);
    ram_en = e;
    idle(3);
    en_model = e;
  endtask

  initial begin
    int unsigned seed;
    logic [15:0] ra;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; addr = '0; rd_wr_n = 1'b1; addr_valid = 1'b0; ram_en = 1'b1;
    bus_e = 1'b0; pwr_good = 1'b1; wdata = '0; en_model = 1'b0;
    idle(3);
    addr_valid = 1'b1; bus_e = 1'b1;
    @(negedge clk);
    check("R10 reset int_sel", {31'd0, int_sel}, 32'd0);
    check("R10 reset dbus_drive", {31'd0, dbus_drive}, 32'd0);
    check("R10 reset rdata", {24'd0, rdata}, 32'd0);
    bus_e = 1'b0; addr_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    en_model = 1'b1;

    // Fill the whole array (R7), then read back (R9).
    for (int i = 0; i < 128; i++) bus_cycle(16'(i), 1'b0, 8'(i * 7 + 3), 1'b1, "R7 fill");
    for (int i = 0; i < 128; i++) bus_cycle(16'(i), 1'b1, 8'h00, 1'b1, "R7 readback");

    // R1: out-of-window alias does not touch byte 0x05.
    bus_cycle(16'h0085, 1'b0, 8'hEE, 1'b1, "R1 alias write");
    bus_cycle(16'h8005, 1'b0, 8'hEE, 1'b1, "R1 high alias write");
    bus_cycle(16'h0085, 1'b1, 8'h00, 1'b1, "R1 alias read");
    bus_cycle(16'h0005, 1'b1, 8'h00, 1'b1, "R1 byte 05 kept");
    bus_cycle(16'h007F, 1'b1, 8'h00, 1'b1, "R1 top byte");

    // R5: unqualified write ignored.
    bus_cycle(16'h0010, 1'b0, 8'h11, 1'b0, "R5 no valid write");
    bus_cycle(16'h0010, 1'b1, 8'h00, 1'b1, "R5 byte kept");

    // R2: enable low blocks all access.
    set_en(1'b0);
    bus_cycle(16'h0040, 1'b0, 8'h99, 1'b1, "R2 disabled write");
    bus_cycle(16'h0040, 1'b1, 8'h00, 1'b1, "R2 disabled read");
    set_en(1'b1);
    bus_cycle(16'h0040, 1'b1, 8'h00, 1'b1, "R2 byte kept");

    // Random traffic (R6, R7, R9).
    for (int i = 0; i < 600; i++) begin
      ra = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 160);
      bus_cycle(ra, 1'($urandom % 2), 8'($urandom), ($urandom % 10) != 0, "R6 random");
    end

    // R3/R8: power loss with enable dropped first.
    set_en(1'b0);
    pwr_good = 1'b0;
    idle(5);
    pwr_good = 1'b1;
    for (int i = 32; i < 128; i++) model[i] = 8'hA5;
    set_en(1'b1);
    for (int i = 0; i < 32; i++)   bus_cycle(16'(i), 1'b1, 8'h00, 1'b1, "R3 retained");
    for (int i = 32; i < 128; i++) bus_cycle(16'(i), 1'b1, 8'h00, 1'b1, "R8 poisoned");

    // R8: write during power loss does not land (enable kept high).
    pwr_good = 1'b0;
    bus_cycle(16'h0003, 1'b0, 8'h5A, 1'b1, "R8 write no power");
    pwr_good = 1'b1;
    bus_cycle(16'h0003, 1'b1, 8'h00, 1'b1, "R8 byte 03 kept");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule